// File: doc/BRIEF.md
# Dual Time-of-Day Alarm Comparator

This block holds the comparison and flag logic for two programmable alarms of a real-time clock. Once per second a strobe asks it to compare the current calendar bytes (seconds, minutes, hours, day of week, date of month) against the stored alarm bytes. The first alarm has seconds, minutes, hours and day/date bytes. The second alarm has minutes, hours and day/date bytes, and its seconds are fixed at zero.

Each alarm byte has a mask bit in bit 7. A masked byte does not take part in the comparison, so the masks make an alarm repeat every second, every minute, every hour, or on a day or date match. In each day/date byte, bit 6 selects whether bits 5:0 are compared with the day of week or with the date of month.

A match sets a sticky flag per alarm. Software clears the flag with a one-cycle strobe. An active-low interrupt line goes low while a set flag has its enable on and the interrupt-mode bit is on. All register storage, bus access and square-wave generation sit outside this block.

Top module: `rtc_alarm_pair`

## Requirements
- R1: After a synchronous active-low reset, both flags are 0 and `irq_n` is 1.
- R2: When `tick` is 1 and every unmasked byte of alarm 1 matches, `flag1` is 1 after that clock edge. An unmasked seconds, minutes or hours byte matches when the current byte equals `{1'b0, alarm[6:0]}`.
- R3: A byte with bit 7 set is left out of the comparison. With all four bytes masked, alarm 1 sets its flag on every `tick`.
- R4: In a day/date byte, bit 6 = 1 compares the current day of week with `{2'b00, alarm[5:0]}`, and bit 6 = 0 compares the current date with `{2'b00, alarm[5:0]}`. The other current field has no effect.
- R5: Alarm 2 compares minutes, hours and day/date like alarm 1, and also requires the current seconds to equal 00h. With all three bytes masked, alarm 2 sets its flag on each `tick` with seconds = 00h, and on no other `tick`.
- R6: When `tick` is 0, no comparison takes place and no flag goes from 0 to 1.
- R7: A set flag stays at 1 until its clear strobe (`clr1` or `clr2`) is 1 at a clock edge. It then reads 0 after that edge, unless R8 applies.
- R8: A match on `tick` in the same cycle as the clear strobe for that alarm leaves the flag at 1.
- R9: `irq_n` is 0 exactly when `int_mode` is 1 and (`flag1` and `ien1`) or (`flag2` and `ien2`). It follows the flags with no extra register stage.
- R10: A flag is set on a match whatever the state of its enable and of `int_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Once-per-second compare strobe |
| cur_sec | input | 8 | Current seconds |
| cur_min | input | 8 | Current minutes |
| cur_hour | input | 8 | Current hours, including the 12/24 and AM/PM bits |
| cur_day | input | 8 | Current day of week |
| cur_date | input | 8 | Current date of month |
| a1_sec | input | 8 | Alarm 1 seconds byte (bit 7 = mask) |
| a1_min | input | 8 | Alarm 1 minutes byte (bit 7 = mask) |
| a1_hour | input | 8 | Alarm 1 hours byte (bit 7 = mask) |
| a1_dd | input | 8 | Alarm 1 day/date byte (bit 7 = mask, bit 6 = day select) |
| a2_min | input | 8 | Alarm 2 minutes byte (bit 7 = mask) |
| a2_hour | input | 8 | Alarm 2 hours byte (bit 7 = mask) |
| a2_dd | input | 8 | Alarm 2 day/date byte (bit 7 = mask, bit 6 = day select) |
| ien1 | input | 1 | Interrupt enable for alarm 1 |
| ien2 | input | 1 | Interrupt enable for alarm 2 |
| int_mode | input | 1 | Routes alarm interrupts to `irq_n` when 1 |
| clr1 | input | 1 | Clear strobe for flag 1 |
| clr2 | input | 1 | Clear strobe for flag 2 |
| flag1 | output | 1 | Sticky match flag of alarm 1 |
| flag2 | output | 1 | Sticky match flag of alarm 2 |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The functions that can fall in one cycle are the once-per-second compare that sets a flag and the software strobe that clears it. The bench drives `tick`, a match and `clr1` or `clr2` in the same cycle, both on purpose and by random draws. It expects the flag to stay at 1, and a later clear with no match to drop it. Each random cycle is also judged against a bench model of both flags and of `irq_n`.

// File: rtl/rtc_alarm_pkg.sv
// Package: shared widths, bit positions and byte type for the alarm comparator.
package rtc_alarm_pkg;
    localparam int BYTE_W   = 8;
    localparam int MASK_POS = 7;    // mask bit in every alarm byte
    localparam int SEL_POS  = 6;    // day(1)/date(0) select in day/date bytes
    localparam int TIME_W   = MASK_POS;  // compared width of a time byte
    localparam int DD_W     = SEL_POS;   // compared width of a day/date byte
    typedef logic [BYTE_W-1:0] rbyte_t;
endpackage

// File: rtl/rtc_time_field_cmp.sv
// Compares one seconds/minutes/hours alarm byte with the current byte.
// Assumes: bit MASK_POS of the alarm byte is the mask. The rest of the byte
// is compared with the whole current byte, whose top bit is expected to be 0.
module rtc_time_field_cmp
    import rtc_alarm_pkg::*;
(
    input  rbyte_t alm,
    input  rbyte_t cur,
    output logic   hit
);
    rbyte_t ref_val;

    // Purpose: build the compare value with the mask bit cleared.
    always_comb begin
        ref_val = {1'b0, alm[TIME_W-1:0]};
    end

    // Purpose: a masked byte always matches, otherwise an exact match is needed.
    always_comb begin
        hit = alm[MASK_POS] | (cur == ref_val);
    end
endmodule

// File: rtl/rtc_daydate_cmp.sv
// Compares a day/date alarm byte with either the day of week or the date.
// Assumes: bit MASK_POS is the mask and bit SEL_POS picks the day of week (1)
// or the date of month (0). The low DD_W bits hold the value.
module rtc_daydate_cmp
    import rtc_alarm_pkg::*;
(
    input  rbyte_t alm,
    input  rbyte_t cur_day,
    input  rbyte_t cur_date,
    output logic   hit
);
    localparam int PAD_W = BYTE_W - DD_W;

    rbyte_t ref_val;
    rbyte_t picked;

    // Purpose: zero-extend the stored value and select the current field.
    always_comb begin
        ref_val = {{PAD_W{1'b0}}, alm[DD_W-1:0]};
        picked  = alm[SEL_POS] ? cur_day : cur_date;
    end

    // Purpose: a masked byte matches, otherwise the selected field must be equal.
    always_comb begin
        hit = alm[MASK_POS] | (picked == ref_val);
    end
endmodule

// File: rtl/rtc_alarm_unit.sv
// One alarm: compares the time bytes and the day/date byte, and keeps a
// sticky flag. Assumes: tick is a one-cycle strobe. A set from a match
// takes priority over the clear strobe in the same cycle. An alarm with no
// seconds byte is given a fixed unmasked 00h seconds byte by its parent.
module rtc_alarm_unit
    import rtc_alarm_pkg::*;
#(
    parameter int N_TIME = 3   // number of time bytes (sec, min, hour)
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tick,
    input  logic   clr,
    input  rbyte_t alm_time [N_TIME],
    input  rbyte_t cur_time [N_TIME],
    input  rbyte_t alm_dd,
    input  rbyte_t cur_day,
    input  rbyte_t cur_date,
    output logic   flag
);
    logic [N_TIME-1:0] time_hit;
    logic              dd_hit;
    logic              match;

    // One comparator per time byte.
    for (genvar i = 0; i < N_TIME; i++) begin : g_time
        rtc_time_field_cmp u_cmp (
            .alm (alm_time[i]),
            .cur (cur_time[i]),
            .hit (time_hit[i])
        );
    end

    rtc_daydate_cmp u_dd (
        .alm      (alm_dd),
        .cur_day  (cur_day),
        .cur_date (cur_date),
        .hit      (dd_hit)
    );

    // Purpose: the alarm matches when every byte matches.
    always_comb begin
        match = (&time_hit) & dd_hit;
    end

    // Purpose: sticky flag, set on a checked match and cleared by the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else begin
            flag <= (flag & ~clr) | (tick & match);
        end
    end
endmodule

// File: rtl/rtc_alarm_pair.sv
// Top: two alarms and the active-low interrupt combiner.
// Assumes: the calendar bytes are stable around tick. Alarm 2 has no seconds
// byte, so its seconds byte is tied to an unmasked 00h.
module rtc_alarm_pair
    import rtc_alarm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [7:0] cur_sec,
    input  logic [7:0] cur_min,
    input  logic [7:0] cur_hour,
    input  logic [7:0] cur_day,
    input  logic [7:0] cur_date,
    input  logic [7:0] a1_sec,
    input  logic [7:0] a1_min,
    input  logic [7:0] a1_hour,
    input  logic [7:0] a1_dd,
    input  logic [7:0] a2_min,
    input  logic [7:0] a2_hour,
    input  logic [7:0] a2_dd,
    input  logic       ien1,
    input  logic       ien2,
    input  logic       int_mode,
    input  logic       clr1,
    input  logic       clr2,
    output logic       flag1,
    output logic       flag2,
    output logic       irq_n
);
    localparam int N_TIME = 3;

    rbyte_t a1_time  [N_TIME];
    rbyte_t a2_time  [N_TIME];
    rbyte_t now_time [N_TIME];
    logic   req1;
    logic   req2;

    // Purpose: gather the time bytes in sec/min/hour order.
    always_comb begin
        now_time[0] = cur_sec;
        now_time[1] = cur_min;
        now_time[2] = cur_hour;
        a1_time[0]  = a1_sec;
        a1_time[1]  = a1_min;
        a1_time[2]  = a1_hour;
        a2_time[0]  = '0;
        a2_time[1]  = a2_min;
        a2_time[2]  = a2_hour;
    end

    rtc_alarm_unit #(.N_TIME(N_TIME)) u_alarm1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .clr      (clr1),
        .alm_time (a1_time),
        .cur_time (now_time),
        .alm_dd   (a1_dd),
        .cur_day  (cur_day),
        .cur_date (cur_date),
        .flag     (flag1)
    );

    rtc_alarm_unit #(.N_TIME(N_TIME)) u_alarm2 (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .clr      (clr2),
        .alm_time (a2_time),
        .cur_time (now_time),
        .alm_dd   (a2_dd),
        .cur_day  (cur_day),
        .cur_date (cur_date),
        .flag     (flag2)
    );

    // Purpose: per-alarm interrupt requests, then the active-low output.
    always_comb begin
        req1  = flag1 & ien1;
        req2  = flag2 & ien2;
        irq_n = ~(int_mode & (req1 | req2));
    end
endmodule

// File: rtl/rtc_alarm_pair_chk.sv
// Checker bound to rtc_alarm_pair. It watches the ports only.
module rtc_alarm_pair_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic [7:0] cur_sec,
    input logic [7:0] a1_sec,
    input logic [7:0] a1_min,
    input logic [7:0] a1_hour,
    input logic [7:0] a1_dd,
    input logic       int_mode,
    input logic       clr1,
    input logic       clr2,
    input logic       flag1,
    input logic       flag2,
    input logic       irq_n
);
    AST_NO_SET_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !flag1) |=> !flag1);  // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag1 && !clr1) |=> flag1);  // R7
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr2 && !tick) |=> !flag2);  // R7
    AST_ALL_MASKED_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && a1_sec[7] && a1_min[7] && a1_hour[7] && a1_dd[7]) |=> flag1);  // R3
    AST_A2_SECONDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cur_sec != 8'h00 && !flag2) |=> !flag2);  // R5
    AST_IRQ_MODE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !int_mode |-> irq_n);  // R9
    AST_IRQ_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag1 && !flag2) |-> irq_n);  // R9
endmodule

bind rtc_alarm_pair rtc_alarm_pair_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .cur_sec  (cur_sec),
    .a1_sec   (a1_sec),
    .a1_min   (a1_min),
    .a1_hour  (a1_hour),
    .a1_dd    (a1_dd),
    .int_mode (int_mode),
    .clr1     (clr1),
    .clr2     (clr2),
    .flag1    (flag1),
    .flag2    (flag2),
    .irq_n    (irq_n)
);

// File: tb/sim_rtc_alarm_pair.sv
`timescale 1ns/1ps
module sim_rtc_alarm_pair;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_day = '0, cur_date = '0;
    logic [7:0] a1_sec = '0, a1_min = '0, a1_hour = '0, a1_dd = '0;
    logic [7:0] a2_min = '0, a2_hour = '0, a2_dd = '0;
    logic ien1 = 1'b0, ien2 = 1'b0, int_mode = 1'b0, clr1 = 1'b0, clr2 = 1'b0;
    logic flag1, flag2, irq_n;
    logic mf1 = 1'b0, mf2 = 1'b0;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rtc_alarm_pair u0 (.*);

    function automatic bit tmatch(logic [7:0] a, logic [7:0] c);
        return a[7] || (c == {1'b0, a[6:0]});
    endfunction

    function automatic bit dmatch(logic [7:0] a, logic [7:0] day, logic [7:0] date);
        if (a[7]) return 1'b1;
        return a[6] ? (day == {2'b00, a[5:0]}) : (date == {2'b00, a[5:0]});
    endfunction

    function automatic bit m1();
        return tmatch(a1_sec, cur_sec) && tmatch(a1_min, cur_min) &&
               tmatch(a1_hour, cur_hour) && dmatch(a1_dd, cur_day, cur_date);
    endfunction

    function automatic bit m2();
        return (cur_sec == 8'h00) && tmatch(a2_min, cur_min) &&
               tmatch(a2_hour, cur_hour) && dmatch(a2_dd, cur_day, cur_date);
    endfunction

    task automatic chk(string tag, logic got, logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%b exp=%b at %0t", tag, got, exp, $time);
        end
    endtask

    // Applies one clock edge with the current inputs and checks all outputs.
    task automatic step(string tag);
        logic n1, n2;
        n1 = (mf1 & ~clr1) | (tick & m1());
        n2 = (mf2 & ~clr2) | (tick & m2());
        @(posedge clk);
        #1;
        mf1 = n1;
        mf2 = n2;
        chk({tag, " flag1"}, flag1, mf1);
        chk({tag, " flag2"}, flag2, mf2);
        chk({tag, " irq_n"}, irq_n, ~(int_mode & ((mf1 & ien1) | (mf2 & ien2))));
        @(negedge clk);
        tick = 1'b0;
        clr1 = 1'b0;
        clr2 = 1'b0;
    endtask

    task automatic clear_all();
        clr1 = 1'b1;
        clr2 = 1'b1;
        step("R7 clear");
    endtask

    task automatic set_now(logic [7:0] s, logic [7:0] m, logic [7:0] h,
                           logic [7:0] dy, logic [7:0] dt);
        cur_sec = s; cur_min = m; cur_hour = h; cur_day = dy; cur_date = dt;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 flag1", flag1, 1'b0);
        chk("R1 flag2", flag2, 1'b0);
        chk("R1 irq_n", irq_n, 1'b1);
        rst_n = 1'b1;

        // R2 and R10: full match with enables off
        set_now(8'h25, 8'h14, 8'h52, 8'h03, 8'h17);
        a1_sec = 8'h25; a1_min = 8'h14; a1_hour = 8'h52; a1_dd = 8'h17;
        a2_min = 8'h00; a2_hour = 8'h00; a2_dd = 8'h01;
        step("R6 no tick");
        tick = 1'b1; step("R2 R10 full match");
        chk("R10 flag1 enables off", flag1, 1'b1);
        clear_all();
        a1_sec = 8'h26; tick = 1'b1; step("R2 seconds differ");

        // R3: every byte masked, values unrelated
        a1_sec = 8'h80; a1_min = 8'hBF; a1_hour = 8'h81; a1_dd = 8'hC5;
        tick = 1'b1; step("R3 all masked");
        chk("R3 flag1", flag1, 1'b1);
        clear_all();

        // R4: day select and date select
        a1_dd = 8'h43;
        tick = 1'b1; step("R4 day select");
        chk("R4 day hit", flag1, 1'b1);
        clear_all();
        a1_dd = 8'h03;
        tick = 1'b1; step("R4 date select miss");
        chk("R4 date miss", flag1, 1'b0);
        a1_dd = 8'h17;
        tick = 1'b1; step("R4 date select hit");
        clear_all();

        // R5: alarm 2 all masked needs seconds 00
        a1_sec = 8'h00; a1_min = 8'h00; a1_hour = 8'h00; a1_dd = 8'h00;
        a2_min = 8'h80; a2_hour = 8'h80; a2_dd = 8'h80;
        tick = 1'b1; step("R5 seconds nonzero");
        chk("R5 no fire", flag2, 1'b0);
        cur_sec = 8'h00;
        tick = 1'b1; step("R5 seconds zero");
        chk("R5 fire", flag2, 1'b1);

        // R9: interrupt routing
        ien2 = 1'b1; step("R9 mode off");
        int_mode = 1'b1; step("R9 mode on");
        chk("R9 irq low", irq_n, 1'b0);
        ien2 = 1'b0; step("R9 enable off");

        // R8: match and clear in one cycle
        tick = 1'b1; clr2 = 1'b1; step("R8 set wins");
        chk("R8 flag2 kept", flag2, 1'b1);
        clr2 = 1'b1; step("R7 clear after");
        chk("R7 flag2 cleared", flag2, 1'b0);

        // Random mix, all requirements: R2 R3 R4 R5 R6 R7 R8 R9
        for (int n = 0; n < 3000; n++) begin
            set_now(8'($urandom % 4), 8'($urandom % 3), 8'($urandom % 3),
                    8'($urandom % 3), 8'($urandom % 3));
            a1_sec  = {1'($urandom % 4 == 0), 7'($urandom % 4)};
            a1_min  = {1'($urandom % 4 == 0), 7'($urandom % 3)};
            a1_hour = {1'($urandom % 4 == 0), 7'($urandom % 3)};
            a1_dd   = {1'($urandom % 4 == 0), 1'($urandom), 6'($urandom % 3)};
            a2_min  = {1'($urandom % 3 == 0), 7'($urandom % 3)};
            a2_hour = {1'($urandom % 3 == 0), 7'($urandom % 3)};
            a2_dd   = {1'($urandom % 3 == 0), 1'($urandom), 6'($urandom % 3)};
            ien1 = 1'($urandom); ien2 = 1'($urandom); int_mode = 1'($urandom);
            tick = 1'($urandom % 2 == 0);
            clr1 = 1'($urandom % 4 == 0);
            clr2 = 1'($urandom % 4 == 0);
            step("R2 R5 R8 random");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule